// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out one atomic memory operation at a time on a word of configurable width. Once an operation is accepted, the unit fetches the addressed word over a simple request/acknowledge memory port, merges it with a source operand using one of nine combine functions, stores the merged word back to the same address, and hands the fetched word back as the instruction's result, with a one-cycle completion strobe.

While the fetch and the store are in flight, a lock output tells the memory system to keep other agents off the bus. Two ordering flags come with each operation. The release flag makes the unit wait until an external "earlier traffic drained" signal is high before it touches memory. The acquire flag raises a hold-off output that keeps younger accesses back until the store has finished or has been dropped.

Two shortcuts save bus cycles. A swap whose result is discarded (destination register is the zero register) skips the fetch. A merged value equal to the fetched one skips the store.

Top module: `amo_unit`

## Requirements
- R1: After reset, busy, done, lock, hold_off and mem_req are all low.
- R2: The op input uses these 5-bit codes: add 00000, swap 00001, xor 00100, or 01000, and 01100, signed min 10000, signed max 10100, unsigned min 11000, unsigned max 11100. A start with any other code is ignored: there is no memory request, no done and busy stays low.
- R3: The stored value is mem+src (modulo 2^XLEN) for add, src for swap, and the bitwise XOR, OR or AND of mem and src for the logic codes.
- R4: For the min and max codes, the stored value is the smaller or larger of mem and src, compared as two's-complement numbers for the signed codes and as unsigned numbers for the unsigned codes.
- R5: An operation issues a read (mem_we=0), then a write (mem_we=1) to the same address. Then done is high for exactly one cycle, with result equal to the word returned by the read.
- R6: When the merged value equals the word read, no write is issued, and done still follows.
- R7: A swap with rd_zero high issues no read. It writes src and returns result 0.
- R8: With rl set at acceptance, no memory request is issued while drained is low. With rl clear, drained has no effect.
- R9: With aq set at acceptance, hold_off is high from the cycle after acceptance until the write is acknowledged or skipped, and is low in the done cycle. With aq clear, hold_off stays low.
- R10: lock is high in every cycle in which a memory request is outstanding, stays high without a break from the read acknowledge to the write acknowledge, and is low whenever the unit is idle.
- R11: A memory request stays asserted with stable direction, address and write data until mem_ack is seen high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept an operation (taken only when idle) |
| op | input | 5 | Combine operation code |
| aq | input | 1 | Acquire ordering flag |
| rl | input | 1 | Release ordering flag |
| rd_zero | input | 1 | Destination is the zero register |
| src | input | XLEN | Source operand |
| addr | input | AW | Word address |
| drained | input | 1 | Earlier memory traffic has completed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | XLEN | Original memory word (0 for a skipped read) |
| hold_off | output | 1 | Keep later accesses back |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request address |
| mem_wdata | output | XLEN | Write data |
| mem_ack | input | 1 | Request accepted (read data valid in that cycle) |
| mem_rdata | input | XLEN | Read data |
| lock | output | 1 | Bus lock held across the read and the write |

## Verification
The bench builds the unit with XLEN=4 and AW=3. At that width every pair of memory word and source operand can be run through each of the nine operations, so each signed/unsigned ordering boundary, the sign-bit crossing, add wrap-around and every equal-value case that drops the store is reached. The memory acknowledge latency cycles from zero to two wait states, and the ordering flags rotate across the sweep. Directed runs then hold drained low under release, use a discarded-result swap, and issue unsupported codes.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam logic [4:0] OPC_ADD  = 5'b00000;
  localparam logic [4:0] OPC_SWAP = 5'b00001;
  localparam logic [4:0] OPC_XOR  = 5'b00100;
  localparam logic [4:0] OPC_OR   = 5'b01000;
  localparam logic [4:0] OPC_AND  = 5'b01100;
  localparam logic [4:0] OPC_MIN  = 5'b10000;
  localparam logic [4:0] OPC_MAX  = 5'b10100;
  localparam logic [4:0] OPC_MINU = 5'b11000;
  localparam logic [4:0] OPC_MAXU = 5'b11100;

  typedef enum logic [3:0] {
    K_ADD, K_SWAP, K_XOR, K_OR, K_AND, K_MIN, K_MAX, K_MINU, K_MAXU
  } amo_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DRAIN, S_READ, S_WRITE, S_DONE
  } amo_state_e;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [4:0] op,
  output amo_kind_e  kind,
  output logic       legal
);

  always_comb begin
    legal = 1'b1;
    kind  = K_ADD;
    case (op)
      OPC_ADD:  kind = K_ADD;
      OPC_SWAP: kind = K_SWAP;
      OPC_XOR:  kind = K_XOR;
      OPC_OR:   kind = K_OR;
      OPC_AND:  kind = K_AND;
      OPC_MIN:  kind = K_MIN;
      OPC_MAX:  kind = K_MAX;
      OPC_MINU: kind = K_MINU;
      OPC_MAXU: kind = K_MAXU;
      default:  legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/amo_combine.sv
module amo_combine
  import amo_pkg::*;
#(
  parameter int W = 32
) (
  input  amo_kind_e      kind,
  input  logic [W-1:0]   mem_val,
  input  logic [W-1:0]   src_val,
  output logic [W-1:0]   merged
);

  function automatic logic [W-1:0] combine(amo_kind_e k, logic [W-1:0] m, logic [W-1:0] s);
    logic s_lt, u_lt;
    s_lt = $signed(m) < $signed(s);
    u_lt = m < s;
    case (k)
      K_ADD:   combine = m + s;
      K_SWAP:  combine = s;
      K_XOR:   combine = m ^ s;
      K_OR:    combine = m | s;
      K_AND:   combine = m & s;
      K_MIN:   combine = s_lt ? m : s;
      K_MAX:   combine = s_lt ? s : m;
      K_MINU:  combine = u_lt ? m : s;
      K_MAXU:  combine = u_lt ? s : m;
      default: combine = m;
    endcase
  endfunction

  assign merged = combine(kind, mem_val, src_val);

  always_comb begin
    if (!$isunknown({kind, mem_val, src_val})) begin
      if (kind == K_MINU) begin
        // R4
        minu_bound_chk: assert (merged <= mem_val && merged <= src_val);
      end
      if (kind == K_MAXU) begin
        // R4
        maxu_bound_chk: assert (merged >= mem_val && merged >= src_val);
      end
    end
  end

endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 30
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  amo_kind_e      kind_in,
  input  logic           aq,
  input  logic           rl,
  input  logic           rd_zero,
  input  logic [W-1:0]   src,
  input  logic [AW-1:0]  addr,
  input  logic           drained,
  input  logic [W-1:0]   merged,
  output amo_kind_e      kind_q,
  output logic [W-1:0]   src_q,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   result,
  output logic           hold_off,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [W-1:0]   mem_wdata,
  input  logic           mem_ack,
  input  logic [W-1:0]   mem_rdata,
  output logic           lock
);

  amo_state_e    state;
  logic          aq_q, rl_q, skip_rd_q, drain_seen_q;
  logic [AW-1:0] addr_q;
  logic [W-1:0]  old_q, wdata_q;

  logic rd_hs, wr_hs, write_skip, skip_rd_in;

  assign skip_rd_in = (kind_in == K_SWAP) && rd_zero;
  assign rd_hs      = (state == S_READ)  && mem_ack;
  assign wr_hs      = (state == S_WRITE) && mem_ack;
  assign write_skip = rd_hs && (merged == mem_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      kind_q       <= K_ADD;
      aq_q         <= 1'b0;
      rl_q         <= 1'b0;
      skip_rd_q    <= 1'b0;
      drain_seen_q <= 1'b0;
      addr_q       <= '0;
      src_q        <= '0;
      old_q        <= '0;
      wdata_q      <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            kind_q       <= kind_in;
            aq_q         <= aq;
            rl_q         <= rl;
            skip_rd_q    <= skip_rd_in;
            drain_seen_q <= drained;
            addr_q       <= addr;
            src_q        <= src;
            old_q        <= '0;
            wdata_q      <= src;
            if (rl && !drained) state <= S_DRAIN;
            else if (skip_rd_in) state <= S_WRITE;
            else                 state <= S_READ;
          end
        end
        S_DRAIN: begin
          if (drained) begin
            drain_seen_q <= 1'b1;
            state        <= skip_rd_q ? S_WRITE : S_READ;
          end
        end
        S_READ: begin
          if (mem_ack) begin
            old_q   <= mem_rdata;
            wdata_q <= merged;
            state   <= write_skip ? S_DONE : S_WRITE;
          end
        end
        S_WRITE: begin
          if (wr_hs) state <= S_DONE;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign result    = old_q;
  assign mem_req   = (state == S_READ) || (state == S_WRITE);
  assign mem_we    = (state == S_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign lock      = mem_req;
  assign hold_off  = aq_q && ((state == S_DRAIN) || (state == S_READ) || (state == S_WRITE));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R8
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && rl_q) |-> drain_seen_q);

  // R10
  lock_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hs && !write_skip) |=> (lock && mem_we));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  acquire_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && aq_q) |-> hold_off);

  // R6
  skip_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_skip |=> (done && !mem_req));

  // R7
  no_read_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && skip_rd_q) |-> mem_we);

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [4:0]      op,
  input  logic            aq,
  input  logic            rl,
  input  logic            rd_zero,
  input  logic [XLEN-1:0] src,
  input  logic [AW-1:0]   addr,
  input  logic            drained,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic            hold_off,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            lock
);

  amo_kind_e       kind_dec, kind_q;
  logic            legal, accept;
  logic [XLEN-1:0] src_q, merged;

  amo_decode u_decode (
    .op    (op),
    .kind  (kind_dec),
    .legal (legal)
  );

  assign accept = start && legal && !busy;

  amo_combine #(.W(XLEN)) u_combine (
    .kind    (kind_q),
    .mem_val (mem_rdata),
    .src_val (src_q),
    .merged  (merged)
  );

  amo_seq #(.W(XLEN), .AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .kind_in   (kind_dec),
    .aq        (aq),
    .rl        (rl),
    .rd_zero   (rd_zero),
    .src       (src),
    .addr      (addr),
    .drained   (drained),
    .merged    (merged),
    .kind_q    (kind_q),
    .src_q     (src_q),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .hold_off  (hold_off),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .lock      (lock)
  );

  // R2
  illegal_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !legal && !busy) |=> !busy);

  // R10
  idle_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!lock && !mem_req));

endmodule

// File: tb/amo_unit_bench.sv
module amo_unit_bench;

  localparam int PERIOD = 10;
  localparam int W  = 4;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] op = '0;
  logic aq = 1'b0, rl = 1'b0, rd_zero = 1'b0, drained = 1'b1;
  logic [W-1:0] src = '0;
  logic [AW-1:0] addr = '0;
  logic busy, done, hold_off, mem_req, mem_we, lock;
  logic [W-1:0] result, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_ack = 1'b0;

  logic [W-1:0] mem [8];
  int rd_cnt = 0, wr_cnt = 0;
  int lat = 0, wait_cnt = 0;
  int errors = 0, checks = 0;
  bit cur_aq = 0, saw_hold = 0, saw_done = 0;

  always #(PERIOD/2) clk = ~clk;

  amo_unit #(.XLEN(W), .AW(AW)) u_amo_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .aq(aq), .rl(rl),
    .rd_zero(rd_zero), .src(src), .addr(addr), .drained(drained),
    .busy(busy), .done(done), .result(result), .hold_off(hold_off),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .lock(lock)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (mem_req) begin
      if (wait_cnt >= lat) begin mem_ack <= 1'b1; wait_cnt <= 0; end
      else begin mem_ack <= 1'b0; wait_cnt <= wait_cnt + 1; end
    end else begin
      mem_ack <= 1'b0; wait_cnt <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // protocol monitors, evaluated between edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) check(lock, "R10 lock during request", lock, 1);
      if (!busy && lock) check(0, "R10 lock while idle", lock, 0);
      if (hold_off) saw_hold = 1;
      if (hold_off && !cur_aq) check(0, "R9 hold_off without acquire", hold_off, 0);
      if (cur_aq && mem_req) check(hold_off, "R9 hold_off during access", hold_off, 1);
      if (done) saw_done = 1;
    end
  end

  function automatic int sx(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  function automatic logic [W-1:0] model(input logic [4:0] c, input logic [W-1:0] m, input logic [W-1:0] s);
    int sum;
    case (c)
      5'b00000: begin sum = int'(m) + int'(s); return sum[W-1:0]; end
      5'b00001: return s;
      5'b00100: return m ^ s;
      5'b01000: return m | s;
      5'b01100: return m & s;
      5'b10000: return (sx(s) < sx(m)) ? s : m;
      5'b10100: return (sx(s) > sx(m)) ? s : m;
      5'b11000: return (int'(s) < int'(m)) ? s : m;
      default:  return (int'(s) > int'(m)) ? s : m;
    endcase
  endfunction

  task automatic issue(input logic [4:0] c, input bit a, input bit r, input bit z,
                       input logic [AW-1:0] ad, input logic [W-1:0] s);
    @(negedge clk);
    op = c; aq = a; rl = r; rd_zero = z; addr = ad; src = s; start = 1'b1;
    cur_aq = a; saw_hold = 0; saw_done = 0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_check(input logic [4:0] c, input bit a, input bit r, input bit z,
                           input logic [AW-1:0] ad, input logic [W-1:0] m, input logic [W-1:0] s,
                           input string req);
    logic [W-1:0] e;
    int r0, w0;
    bit got;
    e = model(c, m, s);
    @(negedge clk);
    mem[ad] = m;
    r0 = rd_cnt; w0 = wr_cnt;
    issue(c, a, r, z, ad, s);
    wait_done(got);
    check(got, {req, " done reached"}, got, 1);
    check(result == (z && c == 5'b00001 ? '0 : m), {"R5 result ", req}, result, m);
    @(negedge clk);
    check(!done, "R5 done one cycle", done, 0);
    check(mem[ad] == e, {req, " stored value"}, mem[ad], e);
    if (z && c == 5'b00001) begin
      check(rd_cnt == r0, "R7 no read", rd_cnt - r0, 0);
      check(wr_cnt == w0 + 1, "R7 one write", wr_cnt - w0, 1);
    end else begin
      check(rd_cnt == r0 + 1, "R5 one read", rd_cnt - r0, 1);
      check(wr_cnt == w0 + (e != m ? 1 : 0), "R6 write only if changed", wr_cnt - w0, (e != m) ? 1 : 0);
    end
    check(saw_hold == a, "R9 hold_off seen iff acquire", saw_hold, a);
    check(!hold_off, "R9 hold_off low after op", hold_off, 0);
    cur_aq = 0;
  endtask

  localparam logic [4:0] OPS [9] = '{5'b00000, 5'b00001, 5'b00100, 5'b01000, 5'b01100,
                                      5'b10000, 5'b10100, 5'b11000, 5'b11100};

  initial begin
    #(PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !lock && !hold_off && !mem_req, "R1 reset outputs",
          {busy, done, lock, hold_off, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4: exhaustive sweep over op, memory word and source
    for (int k = 0; k < 9; k++)
      for (int m = 0; m < 16; m++)
        for (int s = 0; s < 16; s++) begin
          lat = (m + s) % 3;
          run_check(OPS[k], s[0], s[1] & m[0], 1'b0, AW'(m + s), W'(m), W'(s),
                    (k >= 5) ? "R4 minmax" : "R3 arith/logic");
        end
    lat = 1;

    // R7 discarded swap
    run_check(5'b00001, 1'b1, 1'b0, 1'b1, 3'd2, 4'd9, 4'd5, "R7 swap rd_zero");
    // R6 swap with unchanged value
    run_check(5'b00001, 1'b0, 1'b0, 1'b0, 3'd3, 4'd7, 4'd7, "R6 swap equal");

    // R8 release waits on drained
    begin
      int r0;
      bit got;
      r0 = rd_cnt;
      drained = 1'b0;
      mem[5] = 4'd3;
      issue(5'b00000, 1'b1, 1'b1, 1'b0, 3'd5, 4'd4);
      for (int i = 0; i < 6; i++) begin
        check(!mem_req && busy, "R8 no request before drained", mem_req, 0);
        check(hold_off, "R9 hold_off while waiting", hold_off, 1);
        @(negedge clk);
      end
      drained = 1'b1;
      wait_done(got);
      check(got && result == 4'd3, "R8 completes after drained", result, 3);
      @(negedge clk);
      check(mem[5] == 4'd7 && rd_cnt == r0 + 1, "R8 stored after drained", mem[5], 7);
      cur_aq = 0;
    end

    // R8 drained ignored without release
    drained = 1'b0;
    run_check(5'b01000, 1'b0, 1'b0, 1'b0, 3'd1, 4'd8, 4'd1, "R8 rl clear ignores drained");
    drained = 1'b1;

    // R2 unsupported codes ignored
    for (int c = 0; c < 32; c++) begin
      bit legal_c;
      legal_c = 0;
      for (int k = 0; k < 9; k++) if (OPS[k] == 5'(c)) legal_c = 1;
      if (!legal_c) begin
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        issue(5'(c), 1'b1, 1'b0, 1'b0, 3'd0, 4'd1);
        repeat (4) @(negedge clk);
        check(!busy && !saw_done && rd_cnt == r0 && wr_cnt == w0 && !saw_hold,
              "R2 unsupported code ignored", busy, 0);
        cur_aq = 0;
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule